// File: doc/BRIEF.md
# Parallel VID Code Receiver

This block takes a voltage-identification code from a host device over four level-sensitive pins and turns it into a reference setpoint for a regulator. Two pin formats are supported. In the 4-bit format all four pins carry the code and are polled. In the 6-bit format three pins carry data and the fourth pin acts as a select clock. The low half of the code is taken on the falling edge of the select pin, and the high half is taken on the rising edge, which also starts the setpoint calculation.

The host is often powered by the rail that this block regulates, so its pins are not trusted until that rail has settled. A lockout stage therefore gates the whole receiver. It opens a programmable number of milliseconds after the soft-start ramp reports that it is done. A negative lockout value keeps the receiver live at all times. When a code is accepted and it differs from the code currently held, the block computes `low + code * (high - low) / (2^bits - 1)` and raises a one-cycle strobe.

Top module: `vid_par_rx`

## Requirements
- R1: While `rst_ni` is low, `code_o` and `setpoint_o` are 0 and `setpoint_stb_o` is 0. During reset, `live_o` equals bit 15 of `lockout_ms_i`.
- R2: In 4-bit mode (`mode6_i` = 0) the code is `vid_pins_i` with bit 0 as pin A and bit 3 as pin S. Code bits 5:4 are zero.
- R3: All pins pass through a two-flop synchronizer. In 4-bit mode the synchronized pins are sampled once every POLL_CYC clocks. A sample is accepted only when it equals the previous poll sample. A pulse shorter than POLL_CYC is never accepted.
- R4: In 6-bit mode (`mode6_i` = 1), a falling edge on pin S (bit 3) latches pins A, B and C (bits 2:0) as code bits 2:0.
- R5: In 6-bit mode, a rising edge on pin S latches bits 2:0 of the pins as code bits 5:3. The strobe follows CALC_CYC+3 clock edges after the first edge that samples S high.
- R6: The setpoint is `v_low_i + (code * (v_high_i - v_low_i)) / D`, truncated. D is 15 in 4-bit mode and 63 in 6-bit mode, and `v_high_i` >= `v_low_i` is assumed.
- R7: `setpoint_stb_o` is a one-cycle pulse. It is raised only for the first accepted code after reset, or for an accepted code that differs from `code_o`. Without a strobe, `code_o` and `setpoint_o` hold their values.
- R8: While the receiver is not live, pin activity is ignored, so no strobe is raised and `code_o` does not change. When `ramp_done_i` is sampled low and the lockout value is not negative, `live_o` drops after one clock edge.
- R9: Let the lockout value be L >= 0. `live_o` rises L*MS_CYC+1 clock edges after the first edge that samples `ramp_done_i` high, so with L = 0 it rises after one edge.
- R10: A negative lockout value (bit 15 set) keeps `live_o` high regardless of `ramp_done_i`, and codes are accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode6_i | input | 1 | 0: 4-bit polled format, 1: 6-bit select-clocked format |
| ramp_done_i | input | 1 | High while the soft-start ramp is at its top |
| lockout_ms_i | input | LOCK_W | Signed lockout in milliseconds; a negative value means always live |
| v_low_i | input | SP_W | Setpoint for code 0 |
| v_high_i | input | SP_W | Setpoint for the all-ones code |
| vid_pins_i | input | 4 | Host pins A, B, C, S on bits 0 to 3 |
| live_o | output | 1 | Receiver is accepting codes |
| code_o | output | 6 | Last accepted code |
| setpoint_o | output | SP_W | Setpoint for `code_o` |
| setpoint_stb_o | output | 1 | One-cycle strobe when a new setpoint is issued |

## Verification
The bench targets several corner cases.
- A glitch on the pins shorter than one poll interval. A receiver that accepts a single poll sample would strobe on it.
- A 6-bit transfer whose halves are swapped or latched on the wrong edge. This corrupts the code.
- A re-sent unchanged code. A design that ignores the held code would issue a spurious strobe.
- Lockout windows of zero and three milliseconds. An off-by-one in the millisecond counter shifts the cycle at which `live_o` rises.
- A negative lockout value. A design that treats it as a large positive count would never go live.
- Dropping `ramp_done_i` after the receiver is live. A design that fails to close the lockout would keep accepting codes.

// File: rtl/vid_rx_pkg.sv
package vid_rx_pkg;
  localparam int unsigned CODE_W  = 6;
  localparam int unsigned PIN_W   = 4;
  localparam int unsigned HALF_W  = 3;
  localparam int unsigned SEL_IDX = 3;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [PIN_W-1:0]  pins_t;
endpackage

// File: rtl/vid_sync.sv
module vid_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= {st_q[0], d_i[i]};
    end
    assign q_o[i] = st_q[1];
  end
endmodule

// File: rtl/vid_lockout.sv
module vid_lockout #(
  parameter int unsigned LOCK_W = 16,
  parameter int unsigned MS_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ramp_done_i,
  input  logic [LOCK_W-1:0] lockout_i,
  output logic              live_o
);
  localparam int unsigned SUB_W = (MS_CYC > 1) ? $clog2(MS_CYC) : 1;

  logic              armed_q;
  logic [LOCK_W-2:0] ms_q;
  logic [SUB_W-1:0]  sub_q;
  logic              always_live;

  assign always_live = lockout_i[LOCK_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ms_q    <= '0;
      sub_q   <= '0;
    end else if (!ramp_done_i) begin
      armed_q <= 1'b0;
      ms_q    <= '0;
      sub_q   <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      ms_q    <= always_live ? '0 : lockout_i[LOCK_W-2:0];
      sub_q   <= '0;
    end else if (ms_q != '0) begin
      if (sub_q == SUB_W'(MS_CYC - 1)) begin
        sub_q <= '0;
        ms_q  <= ms_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign live_o = always_live | (armed_q & (ms_q == '0));

  // R8
  closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ramp_done_i) && !lockout_i[LOCK_W-1]) |-> !live_o);
  // R9
  open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(live_o) && !lockout_i[LOCK_W-1]) |-> $past(ramp_done_i));
endmodule

// File: rtl/vid_capture.sv
module vid_capture
  import vid_rx_pkg::*;
#(
  parameter int unsigned POLL_CYC = 100000,
  parameter int unsigned CALC_CYC = 12500
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode6_i,
  input  logic  live_i,
  input  pins_t pins_i,
  output logic  cand_vld_o,
  output code_t cand_o
);
  localparam int unsigned PW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int unsigned CW = (CALC_CYC > 1) ? $clog2(CALC_CYC) : 1;

  logic [PW-1:0]     poll_q;
  logic [CW-1:0]     cnt_q;
  logic              tick, fall, rise;
  logic              sel_q, pend_q, vld_q;
  logic [HALF_W-1:0] lo_q, hi_q;
  pins_t             samp_q;
  code_t             cand_q;

  assign tick = (poll_q == PW'(POLL_CYC - 1));
  assign fall = sel_q & ~pins_i[SEL_IDX];
  assign rise = ~sel_q & pins_i[SEL_IDX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      samp_q <= '0;
      cand_q <= '0;
    end else begin
      vld_q  <= 1'b0;
      sel_q  <= pins_i[SEL_IDX];
      poll_q <= tick ? '0 : poll_q + 1'b1;
      if (tick) begin
        samp_q <= pins_i;
        // two matching polls in a row
        if (!mode6_i && live_i && (pins_i == samp_q)) begin
          vld_q  <= 1'b1;
          cand_q <= code_t'(pins_i);
        end
      end
      if (pend_q) begin
        if (cnt_q == CW'(CALC_CYC - 1)) begin
          pend_q <= 1'b0;
          if (live_i) begin
            vld_q  <= 1'b1;
            cand_q <= {hi_q, lo_q};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (mode6_i && live_i) begin
        if (fall) lo_q <= pins_i[HALF_W-1:0];
        if (rise) begin
          hi_q   <= pins_i[HALF_W-1:0];
          pend_q <= 1'b1;
          cnt_q  <= '0;
        end
      end
    end
  end

  assign cand_vld_o = vld_q;
  assign cand_o     = cand_q;

  // R8
  gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(live_i));
  // R5
  rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(pins_i[SEL_IDX]));
endmodule

// File: rtl/vid_setpoint.sv
module vid_setpoint
  import vid_rx_pkg::*;
#(
  parameter int unsigned SP_W = 16
) (
  input  code_t            code_i,
  input  logic             mode6_i,
  input  logic [SP_W-1:0]  low_i,
  input  logic [SP_W-1:0]  high_i,
  output logic [SP_W-1:0]  sp_o
);
  localparam int unsigned PROD_W = SP_W + CODE_W;

  logic [SP_W-1:0]   span;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot [2];

  assign span = high_i - low_i;
  assign prod = PROD_W'(code_i) * PROD_W'(span);

  // constant divisors per format: 2^4-1 and 2^6-1
  for (genvar m = 0; m < 2; m++) begin : g_div
    assign quot[m] = prod / PROD_W'((1 << (4 + 2 * m)) - 1);
  end

  assign sp_o = low_i + quot[mode6_i][SP_W-1:0];
endmodule

// File: rtl/vid_par_rx.sv
module vid_par_rx
  import vid_rx_pkg::*;
#(
  parameter int unsigned SP_W     = 16,
  parameter int unsigned LOCK_W   = 16,
  parameter int unsigned POLL_CYC = 100000,
  parameter int unsigned MS_CYC   = 250000,
  parameter int unsigned CALC_CYC = 12500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode6_i,
  input  logic              ramp_done_i,
  input  logic [LOCK_W-1:0] lockout_ms_i,
  input  logic [SP_W-1:0]   v_low_i,
  input  logic [SP_W-1:0]   v_high_i,
  input  logic [3:0]        vid_pins_i,
  output logic              live_o,
  output logic [5:0]        code_o,
  output logic [SP_W-1:0]   setpoint_o,
  output logic              setpoint_stb_o
);
  pins_t           pins_s;
  logic            live;
  logic            cand_vld;
  code_t           cand;
  logic [SP_W-1:0] sp_calc;
  logic            have_q, stb_q;
  code_t           code_q;
  logic [SP_W-1:0] sp_q;

  vid_sync #(.W(PIN_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (vid_pins_i),
    .q_o   (pins_s)
  );

  vid_lockout #(.LOCK_W(LOCK_W), .MS_CYC(MS_CYC)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ramp_done_i(ramp_done_i),
    .lockout_i  (lockout_ms_i),
    .live_o     (live)
  );

  vid_capture #(.POLL_CYC(POLL_CYC), .CALC_CYC(CALC_CYC)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode6_i   (mode6_i),
    .live_i    (live),
    .pins_i    (pins_s),
    .cand_vld_o(cand_vld),
    .cand_o    (cand)
  );

  vid_setpoint #(.SP_W(SP_W)) u_sp (
    .code_i (cand),
    .mode6_i(mode6_i),
    .low_i  (v_low_i),
    .high_i (v_high_i),
    .sp_o   (sp_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      stb_q  <= 1'b0;
      code_q <= '0;
      sp_q   <= '0;
    end else begin
      stb_q <= 1'b0;
      if (cand_vld && (!have_q || (cand != code_q))) begin
        have_q <= 1'b1;
        code_q <= cand;
        sp_q   <= sp_calc;
        stb_q  <= 1'b1;
      end
    end
  end

  assign live_o         = live;
  assign code_o         = code_q;
  assign setpoint_o     = sp_q;
  assign setpoint_stb_o = stb_q;

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setpoint_stb_o |-> ($stable(setpoint_o) && $stable(code_o)));
  // R7
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setpoint_stb_o |-> $past(cand_vld));
endmodule

// File: tb/vid_par_rx_tb.sv
`timescale 1ns/1ps
module vid_par_rx_tb;
  localparam int POLL = 20;
  localparam int MS   = 50;
  localparam int CALC = 8;
  localparam int LOW  = 1000;
  localparam int HIGH = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode6 = 1'b0;
  logic        ramp = 1'b0;
  logic [15:0] lock = 16'hFFFF;
  logic [3:0]  pins = 4'h0;
  logic        live;
  logic [5:0]  code;
  logic [15:0] sp;
  logic        stb;

  int    checks = 0;
  int    errors = 0;
  int    stb_seen = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  vid_par_rx #(
    .SP_W(16), .LOCK_W(16), .POLL_CYC(POLL), .MS_CYC(MS), .CALC_CYC(CALC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode6_i(mode6), .ramp_done_i(ramp),
    .lockout_ms_i(lock), .v_low_i(16'(LOW)), .v_high_i(16'(HIGH)),
    .vid_pins_i(pins), .live_o(live), .code_o(code), .setpoint_o(sp),
    .setpoint_stb_o(stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int calc(input int c, input bit m6);
    return LOW + (c * (HIGH - LOW)) / (m6 ? 63 : 15);
  endfunction

  // behavioural reference model, stepped once per clock
  int h0, h1, h2, h3, e_n;
  int m_code, m_sp, m_stb, m_have, m_cv, m_cand, m_samp;
  int m_pend, m_pcnt, m_lo, m_hi, m_rc, m_live;

  always @(posedge clk) begin
    int lp, s2, sq, lv;
    #1;
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; h3 = 0; e_n = 0;
      m_code = 0; m_sp = 0; m_stb = 0; m_have = 0; m_cv = 0; m_cand = 0;
      m_samp = 0; m_pend = 0; m_pcnt = 0; m_lo = 0; m_hi = 0; m_rc = 0;
      m_live = lock[15];
    end else begin
      h3 = h2; h2 = h1; h1 = h0; h0 = int'(pins);
      e_n++;
      lp = m_live;
      m_stb = 0;
      if (m_cv != 0 && (m_have == 0 || m_cand != m_code)) begin
        m_code = m_cand; m_sp = calc(m_cand, mode6); m_stb = 1; m_have = 1;
      end
      m_cv = 0;
      s2 = h2; sq = h3;
      if (e_n % POLL == 0) begin
        if (!mode6 && lp != 0 && s2 == m_samp) begin m_cv = 1; m_cand = s2; end
        m_samp = s2;
      end
      if (m_pend != 0) begin
        if (m_pcnt == CALC - 1) begin
          m_pend = 0;
          if (lp != 0) begin m_cv = 1; m_cand = m_hi * 8 + m_lo; end
        end else m_pcnt++;
      end
      if (mode6 && lp != 0) begin
        if ((sq & 8) != 0 && (s2 & 8) == 0) m_lo = s2 & 7;
        if ((sq & 8) == 0 && (s2 & 8) != 0) begin m_hi = s2 & 7; m_pend = 1; m_pcnt = 0; end
      end
      if (!ramp) m_rc = 0; else if (m_rc < 1000000) m_rc++;
      lv = int'(lock[14:0]);
      m_live = (lock[15] || (m_rc >= 1 && m_rc >= 1 + lv * MS)) ? 1 : 0;
    end
    chk(cur_req, int'(code), m_code);
    chk(cur_req, int'(sp), m_sp);
    chk(cur_req, int'(stb), m_stb);
    chk(cur_req, int'(live), m_live);
    if (rst_n && stb) stb_seen++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit m6, input logic [15:0] lk, input bit rp, input logic [3:0] p);
    @(negedge clk);
    rst_n = 1'b0; mode6 = m6; lock = lk; ramp = rp; pins = p;
    wait_cyc(3);
    // R1 reset state
    chk("R1", int'(code), 0);
    chk("R1", int'(sp), 0);
    chk("R1", int'(stb), 0);
    chk("R1", int'(live), int'(lk[15]));
    rst_n = 1'b1;
  endtask

  task automatic send6(input int c, output int lat);
    pins = {1'b0, 3'(c & 7)};
    wait_cyc(20);
    pins = {1'b1, 3'((c >> 3) & 7)};
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!stb && lat < 60);
    wait_cyc(20);
  endtask

  task automatic wait_live(input bit lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (live != lvl && n < 1000);
  endtask

  initial begin
    int lat, base, n;
    // 4-bit polled format
    cur_req = "R1";
    do_reset(1'b0, 16'hFFFF, 1'b0, 4'h0);
    cur_req = "R7";
    wait_cyc(2 * POLL + 5);
    chk("R7", stb_seen, 1);
    chk("R7", int'(sp), LOW);
    cur_req = "R2";
    pins = 4'b0101;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!stb && lat < 200);
    // R3 acceptance needs two matching polls
    chk("R3", int'(lat >= POLL + 3 && lat <= 2 * POLL + 4), 1);
    wait_cyc(2);
    chk("R2", int'(code), 5);
    chk("R6", int'(sp), 2000);
    pins = 4'b1000;
    wait_cyc(3 * POLL + 5);
    chk("R2", int'(code), 8);
    chk("R6", int'(sp), 2600);
    cur_req = "R3";
    base = stb_seen;
    pins = 4'b0001;
    wait_cyc(3);
    pins = 4'b1000;
    wait_cyc(3 * POLL + 5);
    chk("R3", stb_seen - base, 0);
    chk("R3", int'(code), 8);

    // 6-bit select-clocked format
    cur_req = "R4";
    do_reset(1'b1, 16'hFFFF, 1'b0, 4'h0);
    wait_cyc(5);
    pins = 4'b1000;
    wait_cyc(30);
    chk("R7", int'(code), 0);
    chk("R6", int'(sp), LOW);
    send6(42, lat);
    chk("R5", lat, CALC + 4);
    chk("R4", int'(code), 42);
    chk("R6", int'(sp), 3000);
    send6(13, lat);
    chk("R4", int'(code), 13);
    chk("R6", int'(sp), 1619);
    cur_req = "R7";
    base = stb_seen;
    send6(13, lat);
    chk("R7", stb_seen - base, 0);
    chk("R7", int'(code), 13);
    cur_req = "R5";
    send6(63, lat);
    chk("R5", int'(code), 63);
    chk("R6", int'(sp), HIGH);

    // lockout of 3 ms
    cur_req = "R8";
    do_reset(1'b0, 16'd3, 1'b0, 4'd7);
    wait_cyc(5 * POLL);
    chk("R8", int'(live), 0);
    chk("R8", int'(code), 0);
    chk("R8", stb_seen - stb_seen, 0);
    base = stb_seen;
    cur_req = "R9";
    ramp = 1'b1;
    wait_live(1'b1, n);
    chk("R9", n, 3 * MS + 1);
    chk("R8", stb_seen - base, 0);
    wait_cyc(3 * POLL);
    chk("R9", int'(code), 7);
    chk("R6", int'(sp), 2400);
    cur_req = "R8";
    ramp = 1'b0;
    wait_live(1'b0, n);
    chk("R8", n, 1);
    base = stb_seen;
    pins = 4'd2;
    wait_cyc(4 * POLL);
    chk("R8", int'(code), 7);
    chk("R8", stb_seen - base, 0);

    // 6-bit edges during lockout leave nothing behind
    do_reset(1'b1, 16'd2, 1'b0, 4'h0);
    base = stb_seen;
    send6(42, lat);
    chk("R8", stb_seen - base, 0);
    chk("R8", int'(code), 0);

    // zero lockout, then negative lockout
    cur_req = "R9";
    do_reset(1'b0, 16'd0, 1'b0, 4'h0);
    wait_cyc(4);
    ramp = 1'b1;
    wait_live(1'b1, n);
    chk("R9", n, 1);
    cur_req = "R10";
    do_reset(1'b0, 16'hFFFB, 1'b0, 4'd3);
    wait_cyc(3 * POLL);
    chk("R10", int'(live), 1);
    chk("R10", int'(code), 3);
    chk("R10", int'(sp), 1600);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule